// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. A sequencer gives it the accumulator value, a second operand byte and a 4-bit operation code. In the same cycle the block returns the result byte, a strobe that tells the sequencer whether to write the result back to the accumulator, and the candidate status byte. On every cycle with `op_valid` high, the candidate status byte is captured into an internal flag register. Carry-in for the carry-chained operations comes from that register, so a chain of add-with-carry or subtract-with-borrow steps needs no extra wiring.

The status byte holds four flags: zero, subtract, half-carry and carry. Each operation family follows its own rule for every flag: it either computes the flag from the arithmetic, forces it to a fixed value, or leaves it as stored. Choosing operands from a register file, 16-bit arithmetic and decimal adjust are left to neighbouring logic.

Top module: `acc_alu`

## Requirements
- R1: The status byte holds zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3..0 always read 0. After reset the stored byte is 0x00, and asserting reset at any time clears it.
- R2: Op codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 and, 6 or, 7 xor, 8 increment, 9 decrement, 10 complement, 11 set carry and 12 invert carry. Codes 13 to 15 are reserved.
- R3: Add (0) and add-with-carry (1) return the low 8 bits of acc+opnd+cin. Carry-in is the stored carry for code 1 and 0 for code 0. Carry is the carry out of bit 7 and half-carry the carry out of bit 3, both including carry-in, also when opnd+cin reaches 0x100. Subtract is cleared, and zero is set when the result is 0.
- R4: Subtract (2) and subtract-with-borrow (3) return acc-opnd-cin and set the subtract flag. Carry is set on a borrow out of bit 7 and half-carry on a borrow out of bit 3, both including carry-in. Zero follows the result.
- R5: Compare (4) sets flags exactly as subtract does and presents the difference on `res_o`, but never raises `acc_we_o`.
- R6: And (5) sets half-carry and clears subtract and carry. Or (6) and xor (7) clear subtract, half-carry and carry. All three set zero from the result.
- R7: Increment (8) and decrement (9) act on `acc_i` and keep the stored carry. Increment clears subtract and sets half-carry when the low nibble wraps from F to 0. Decrement sets subtract and sets half-carry when the low nibble borrows (low nibble of acc is 0).
- R8: Complement (10) returns ~acc, sets subtract and half-carry, and keeps zero and carry.
- R9: Set carry (11) forces carry to 1, and invert carry (12) inverts it. Both clear subtract and half-carry, keep zero, and return `acc_i` with no write.
- R10: The stored status byte changes only on a clock edge with `op_valid` high. Reserved codes leave it unchanged, return `acc_i` and never raise `acc_we_o`.
- R11: `acc_we_o` is high exactly when `op_valid` is high and the code is 0-3 or 5-10.
- R12: `res_o` and `flg_nxt_o` are combinational in the inputs and the stored byte. `flg_q_o` shows the new byte one clock edge after the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see R2) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| res_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Write result back to the accumulator |
| flg_nxt_o | output | 8 | Candidate status byte |
| flg_q_o | output | 8 | Stored status byte |

## Verification
A wrong carry or half-carry in the adder appears on `flg_nxt_o` in the same cycle for the failing operand pair. The exhaustive sweep of every pair, under both stored carry values, therefore exposes it at once. A stored flag that is captured, held or preserved wrongly appears on `flg_q_o` one edge after the operation. It then corrupts the next carry-chained result, so the directed vectors check the register right after each issue and again after an idle cycle. A decode fault in the write strobe shows on `acc_we_o` in the issuing cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned NIB   = 4;
  localparam int unsigned OPW   = 4;
  localparam int unsigned FLG_Z = 7;
  localparam int unsigned FLG_N = 6;
  localparam int unsigned FLG_H = 5;
  localparam int unsigned FLG_C = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12,
    OP_RS13 = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lg_e;

  function automatic logic [DW-1:0] pack_flags(input logic z, input logic n,
                                               input logic h, input logic c);
    logic [DW-1:0] f;
    f        = '0;
    f[FLG_Z] = z;
    f[FLG_N] = n;
    f[FLG_H] = h;
    f[FLG_C] = c;
    return f;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W   = 8,
  parameter int unsigned NB  = 4
) (
  input  logic         sub,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         hc_out
);
  localparam int unsigned WX = W + 1;
  localparam int unsigned NX = NB + 1;

  // Full-width sum or difference; the top bit is carry or borrow.
  function automatic logic [WX-1:0] wide_op(input logic s, input logic [W-1:0] x,
                                            input logic [W-1:0] y, input logic ci);
    if (s) return {1'b0, x} - {1'b0, y} - WX'(ci);
    else   return {1'b0, x} + {1'b0, y} + WX'(ci);
  endfunction

  // Low-nibble sum or difference; the top bit is half carry or half borrow.
  function automatic logic [NX-1:0] nib_op(input logic s, input logic [NB-1:0] x,
                                           input logic [NB-1:0] y, input logic ci);
    if (s) return {1'b0, x} - {1'b0, y} - NX'(ci);
    else   return {1'b0, x} + {1'b0, y} + NX'(ci);
  endfunction

  logic [WX-1:0] full_w;
  logic [NX-1:0] low_w;

  always_comb begin
    full_w = wide_op(sub, a, b, cin);
    low_w  = nib_op(sub, a[NB-1:0], b[NB-1:0], cin);
  end

  assign res    = full_w[W-1:0];
  assign cy_out = full_w[W];
  assign hc_out = low_w[NB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 8
) (
  input  acc_alu_pkg::lg_e sel,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     res
);
  import acc_alu_pkg::*;

  always_comb begin
    case (sel)
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
  end
endmodule

// File: rtl/alu_incdec.sv
module alu_incdec #(
  parameter int unsigned W  = 8,
  parameter int unsigned NB = 4
) (
  input  logic         dec,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         hc_out
);
  function automatic logic nib_edge(input logic d, input logic [NB-1:0] x);
    // Increment wraps at all ones; decrement borrows at all zeros.
    if (d) return x == '0;
    else   return x == '1;
  endfunction

  assign res    = dec ? a - W'(1) : a + W'(1);
  assign hc_out = nib_edge(dec, a[NB-1:0]);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int unsigned W  = 8,
  parameter int unsigned LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= {nxt[W-1:LO], {LO{1'b0}}};
  end

  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q[LO-1:0] == '0);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_sel,
  input  logic [7:0]   acc_i,
  input  logic [7:0]   opnd_i,
  output logic [7:0]   res_o,
  output logic         acc_we_o,
  output logic [7:0]   flg_nxt_o,
  output logic [7:0]   flg_q_o
);
  op_e           op;
  logic          as_sub, as_cin;
  logic [DW-1:0] as_res, lg_res, id_res;
  logic          as_cy, as_hc, id_hc;
  lg_e           lg_sel;
  logic          is_dec;
  logic          writes;
  logic          res_zero;
  logic          st_z, st_c;
  logic [DW-1:0] flg_q;

  assign op    = op_e'(op_sel);
  assign st_z  = flg_q[FLG_Z];
  assign st_c  = flg_q[FLG_C];

  // Operand path steering
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) && st_c;
  assign is_dec = (op == OP_DEC);

  always_comb begin
    case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_addsub #(.W(DW), .NB(NIB)) u_addsub (
    .sub(as_sub), .cin(as_cin), .a(acc_i), .b(opnd_i),
    .res(as_res), .cy_out(as_cy), .hc_out(as_hc)
  );

  alu_logic #(.W(DW)) u_logic (
    .sel(lg_sel), .a(acc_i), .b(opnd_i), .res(lg_res)
  );

  alu_incdec #(.W(DW), .NB(NIB)) u_incdec (
    .dec(is_dec), .a(acc_i), .res(id_res), .hc_out(id_hc)
  );

  // Result selection and flag rules per family
  always_comb begin
    res_o     = acc_i;
    writes    = 1'b0;
    flg_nxt_o = flg_q;
    case (op)
      OP_ADD, OP_ADC: begin
        res_o     = as_res;
        writes    = 1'b1;
        flg_nxt_o = pack_flags(as_res == '0, 1'b0, as_hc, as_cy);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res_o     = as_res;
        writes    = (op != OP_CMP);
        flg_nxt_o = pack_flags(as_res == '0, 1'b1, as_hc, as_cy);
      end
      OP_AND: begin
        res_o     = lg_res;
        writes    = 1'b1;
        flg_nxt_o = pack_flags(lg_res == '0, 1'b0, 1'b1, 1'b0);
      end
      OP_OR, OP_XOR: begin
        res_o     = lg_res;
        writes    = 1'b1;
        flg_nxt_o = pack_flags(lg_res == '0, 1'b0, 1'b0, 1'b0);
      end
      OP_INC, OP_DEC: begin
        res_o     = id_res;
        writes    = 1'b1;
        flg_nxt_o = pack_flags(id_res == '0, is_dec, id_hc, st_c);
      end
      OP_CPL: begin
        res_o     = ~acc_i;
        writes    = 1'b1;
        flg_nxt_o = pack_flags(st_z, 1'b1, 1'b1, st_c);
      end
      OP_SCF: flg_nxt_o = pack_flags(st_z, 1'b0, 1'b0, 1'b1);
      OP_CCF: flg_nxt_o = pack_flags(st_z, 1'b0, 1'b0, !st_c);
      default: ;
    endcase
  end

  assign res_zero = (res_o == '0);
  assign acc_we_o = op_valid && writes;

  alu_flag_reg #(.W(DW), .LO(FLG_C)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(op_valid), .nxt(flg_nxt_o), .q(flg_q)
  );

  assign flg_q_o = flg_q;

  // Assertions next to the decode they guard
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CMP) |-> !acc_we_o);

  p_add_n_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_ADD || op == OP_ADC)) |=> !flg_q_o[FLG_N]);

  p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_ADD || op == OP_ADC) && res_zero) |=> flg_q_o[FLG_Z]);

  p_sub_n_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && as_sub) |=> flg_q_o[FLG_N]);

  p_and_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_AND) |=> (flg_q_o[FLG_N:FLG_C] == 3'b010));

  p_orx_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_OR || op == OP_XOR)) |=> (flg_q_o[FLG_N:FLG_C] == 3'b000));

  p_incdec_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_INC || op == OP_DEC)) |=> (flg_q_o[FLG_C] == $past(flg_q_o[FLG_C])));

  p_cpl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CPL) |=> (flg_q_o[FLG_N] && flg_q_o[FLG_H] &&
      flg_q_o[FLG_Z] == $past(flg_q_o[FLG_Z]) && flg_q_o[FLG_C] == $past(flg_q_o[FLG_C])));

  p_scf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_SCF) |=> (flg_q_o[FLG_N:FLG_C] == 3'b001 &&
      flg_q_o[FLG_Z] == $past(flg_q_o[FLG_Z])));

  p_ccf_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CCF) |=> (flg_q_o[FLG_C] != $past(flg_q_o[FLG_C]) &&
      !flg_q_o[FLG_N] && !flg_q_o[FLG_H]));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd13) |=> $stable(flg_q_o));

  p_reserved_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd11) |-> !acc_we_o);
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/10ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] res_o, flg_nxt_o, flg_q_o;
  logic       acc_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_i(acc_i), .opnd_i(opnd_i), .res_o(res_o), .acc_we_o(acc_we_o),
    .flg_nxt_o(flg_nxt_o), .flg_q_o(flg_q_o)
  );

  // Independent model: returns {write, result, status byte}
  function automatic logic [16:0] model(input int op, input int a, input int b,
                                        input logic [7:0] old);
    int cin, t, r;
    logic z, n, h, cy, we;
    logic [7:0] f;
    cin = old[4] ? 1 : 0;
    r = a; we = 1'b0; f = old;
    z = 1'b0; n = 1'b0; h = 1'b0; cy = 1'b0;
    if (op <= 1) begin
      t = a + b + ((op == 1) ? cin : 0);
      r = t & 255; cy = (t > 255);
      h = ((a & 15) + (b & 15) + ((op == 1) ? cin : 0)) > 15;
      n = 1'b0; we = 1'b1;
    end else if (op <= 4) begin
      t = a - b - ((op == 3) ? cin : 0);
      r = t & 255; cy = (t < 0);
      h = ((a & 15) - (b & 15) - ((op == 3) ? cin : 0)) < 0;
      n = 1'b1; we = (op != 4);
    end else if (op <= 7) begin
      r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
      h = (op == 5); we = 1'b1;
    end else if (op == 8) begin
      r = (a + 1) & 255; h = ((a & 15) == 15); cy = old[4]; we = 1'b1;
    end else if (op == 9) begin
      r = (a + 255) & 255; h = ((a & 15) == 0); n = 1'b1; cy = old[4]; we = 1'b1;
    end
    if (op <= 9) begin
      z = (r == 0);
      f = {z, n, h, cy, 4'h0};
    end else if (op == 10) begin
      r = (~a) & 255; we = 1'b1;
      f = {old[7], 1'b1, 1'b1, old[4], 4'h0};
    end else if (op == 11) begin
      f = {old[7], 3'b001, 4'h0};
    end else if (op == 12) begin
      f = {old[7], 2'b00, ~old[4], 4'h0};
    end
    return {we, r[7:0], f};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op == 4) return "R5";
    if (op <= 7) return "R6";
    if (op <= 9) return "R7";
    if (op == 10) return "R8";
    if (op <= 12) return "R9";
    return "R10";
  endfunction

  // Issue one op: drive at negedge, capture combinational outputs, let the edge pass
  task automatic issue(input int op, input int a, input int b,
                       output logic [7:0] r, output logic w);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    #1;
    r = res_o; w = acc_we_o;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // {op, a, b, cin, exp_res, exp_flags, exp_we}
  localparam logic [37:0] VEC [20] = '{
    {4'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 8'h20, 1'b1},
    {4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 8'h90, 1'b1},
    {4'd1,  8'h01, 8'hFF, 1'b1, 8'h01, 8'h30, 1'b1},
    {4'd1,  8'h00, 8'hFF, 1'b1, 8'h00, 8'hB0, 1'b1},
    {4'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 8'h20, 1'b1},
    {4'd2,  8'h10, 8'h01, 1'b0, 8'h0F, 8'h60, 1'b1},
    {4'd2,  8'h00, 8'h01, 1'b0, 8'hFF, 8'h70, 1'b1},
    {4'd3,  8'h00, 8'hFF, 1'b1, 8'h00, 8'hF0, 1'b1},
    {4'd3,  8'h10, 8'h0F, 1'b1, 8'h00, 8'hE0, 1'b1},
    {4'd4,  8'h42, 8'h42, 1'b0, 8'h00, 8'hC0, 1'b0},
    {4'd5,  8'hF0, 8'h0F, 1'b1, 8'h00, 8'hA0, 1'b1},
    {4'd6,  8'h00, 8'h00, 1'b1, 8'h00, 8'h80, 1'b1},
    {4'd7,  8'hFF, 8'h0F, 1'b1, 8'hF0, 8'h00, 1'b1},
    {4'd8,  8'hFF, 8'h00, 1'b1, 8'h00, 8'hB0, 1'b1},
    {4'd9,  8'h01, 8'h00, 1'b0, 8'h00, 8'hC0, 1'b1},
    {4'd9,  8'h10, 8'h00, 1'b1, 8'h0F, 8'h70, 1'b1},
    {4'd10, 8'h5A, 8'h00, 1'b1, 8'hA5, 8'h70, 1'b1},
    {4'd11, 8'h33, 8'h00, 1'b0, 8'h33, 8'h10, 1'b0},
    {4'd12, 8'h33, 8'h00, 1'b1, 8'h33, 8'h00, 1'b0},
    {4'd13, 8'h33, 8'h44, 1'b1, 8'h33, 8'h10, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r, held;
    logic w;
    logic [16:0] m;
    logic [7:0] old;

    // R1: reset value
    #2;
    check(flg_q_o == 8'h00, "R1 reset", flg_q_o, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flg_q_o == 8'h00, "R1 after reset", flg_q_o, 8'h00);

    // Directed table walk (R2 encodings)
    for (int i = 0; i < 20; i++) begin
      int op, a, b;
      op = int'(VEC[i][37:34]); a = int'(VEC[i][33:26]); b = int'(VEC[i][25:18]);
      issue(0, 1, 0, r, w);                       // flags -> 0x00
      if (VEC[i][17]) issue(11, 0, 0, r, w);      // flags -> 0x10
      issue(op, a, b, r, w);
      check(r == VEC[i][16:9], {req_of(op), " result"}, r, VEC[i][16:9]);
      check(w == VEC[i][0], {"R11 write strobe ", req_of(op)}, w, VEC[i][0]);
      check(flg_q_o == VEC[i][8:1], {req_of(op), " R12 stored flags"}, flg_q_o, VEC[i][8:1]);
    end

    // R10: no valid -> stored byte unchanged
    issue(0, 8'h80, 8'h80, r, w);                 // 0x90
    held = flg_q_o;
    @(negedge clk);
    op_sel = 4'd2; acc_i = 8'h00; opnd_i = 8'h01;
    @(negedge clk);
    check(flg_q_o == held, "R10 idle hold", flg_q_o, held);
    check(acc_we_o == 1'b0, "R11 idle strobe", acc_we_o, 0);

    // R1: reset mid-run clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(flg_q_o == 8'h00, "R1 async clear", flg_q_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive sweep, stored flags 0x00 then 0x90
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        issue(7, 8'h55, 8'h55, r, w);             // 0x80
        issue(11, 0, 0, r, w);                    // 0x90
      end
      old = (pass == 0) ? 8'h00 : 8'h90;
      check(flg_q_o == old, "R9 sweep setup", flg_q_o, old);
      for (int op = 0; op < 16; op++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            op_sel = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0];
            #0.25;
            m = model(op, a, b, old);
            if (res_o !== m[15:8] || flg_nxt_o !== m[7:0]) begin
              check(1'b0, {req_of(op), " R12 sweep"}, {res_o, flg_nxt_o}, m[15:0]);
            end else begin
              n_chk++;
            end
          end
        end
      end
      check(flg_q_o == old, "R10 hold over sweep", flg_q_o, old);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule